// File: doc/BRIEF.md
# Held-Reading Static LCD Driver

This block sits between the back end of a dual-slope converter and a static liquid-crystal panel. It keeps the last reading in display latches: three full BCD digits, a leading half-digit, and a sign flag. It decodes that reading to seven-segment patterns and drives every segment against a shared backplane square wave. On an unlit segment the output follows the backplane. On a lit segment the output is its inverse, so the pixel sees an AC voltage with no DC part.

The converter pulses `eoc_stb` for one clock at the end of each conversion, and conversions never stop. The `freeze` input is brought in through a two-flop synchroniser. While its synchronised level is high, end-of-conversion strobes are ignored and the reading on the panel stays fixed. When `freeze` is low, which is its idle level, every strobe loads the new result. The backplane period is set from the conversion length, so the backplane completes 20 cycles per conversion.

Top module: `lcd_hold_drv`

## Requirements
- R1: While `rst_n` is low and after its release, the latches hold digits 0,0,0 with half-digit and sign off, and `bp` is 0. At reset, therefore, each digit output equals 7'h3F and `seg_half` and `seg_minus` equal 0.
- R2: An `eoc_stb` sampled high at a clock edge, with the synchronised freeze level low, loads `bcd_in`, `half_in` and `neg_in`. The new pattern appears on the outputs directly after that edge. `bcd_in[3:0]` is units, `[7:4]` is tens and `[11:8]` is hundreds.
- R3: While the synchronised freeze level is high, any number of `eoc_stb` pulses leave every latched value unchanged. No input change other than a strobe alters the latches.
- R4: `freeze` passes through two flip-flops. Its level sampled at edge j governs a strobe sampled at edge j+2. Strobes at edges j and j+1 still use the earlier level, and this holds both when freeze rises and when it falls.
- R5: `bp` holds each level for CONV_CLKS/40 clocks and then toggles. This gives 20 full periods per conversion of CONV_CLKS clocks.
- R6: Every segment output equals `bp` when its segment is off and `~bp` when it is on.
- R7: A digit code 0 to 9 lights the segments, with bit 0 = a through bit 6 = g: 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R8: Digit codes 10 to 15 light no segment.
- R9: `seg_half` is lit when the latched half-digit is 1, and `seg_minus` is lit when the latched sign is 1.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eoc_stb | input | 1 | One-cycle end-of-conversion strobe |
| freeze | input | 1 | Asynchronous hold request, high freezes the reading |
| bcd_in | input | 12 | Result digits: hundreds, tens, units |
| half_in | input | 1 | Leading half-digit (1 shows "1") |
| neg_in | input | 1 | Result is negative |
| seg_units | output | 7 | Units digit segments a..g |
| seg_tens | output | 7 | Tens digit segments a..g |
| seg_hund | output | 7 | Hundreds digit segments a..g |
| seg_half | output | 1 | Half-digit drive (both segments of "1") |
| seg_minus | output | 1 | Minus sign drive |
| bp | output | 1 | Backplane square wave |

## Verification
A strobe can coincide with a change in the synchronised freeze level. In that cycle the outcome depends on which flop stage the freeze change has reached. The bench raises and lowers `freeze` in the same cycle as a strobe and issues strobes back to back after it. It expects the first two strobes to follow the old level and the third to follow the new one, and it compares the latched reading each time. Readings are judged by XORing the outputs with `bp`, so a latch load that lands in a backplane toggle cycle is checked in both phases.

// File: rtl/lcd_hold_drv.sv
module lcd_hold_drv #(
  parameter int CONV_CLKS = 4000,
  parameter int DIGITS    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        eoc_stb,
  input  logic        freeze,
  input  logic [11:0] bcd_in,
  input  logic        half_in,
  input  logic        neg_in,
  output logic [6:0]  seg_units,
  output logic [6:0]  seg_tens,
  output logic [6:0]  seg_hund,
  output logic        seg_half,
  output logic        seg_minus,
  output logic        bp
);
  localparam int BP_HALF = (CONV_CLKS / 40 < 1) ? 1 : CONV_CLKS / 40;
  localparam int CW      = (BP_HALF > 1) ? $clog2(BP_HALF) : 1;
  localparam int DW      = 4 * DIGITS;

  logic [DW-1:0] lat_d;
  logic          lat_half, lat_neg;
  logic          frz_s1, frz_s2;
  logic [CW-1:0] bp_cnt;
  logic [6:0]    pat [DIGITS];

  wire load = eoc_stb && !frz_s2;

  function automatic logic [6:0] dec7(input logic [3:0] v);
    case (v)
      4'd0: dec7 = 7'h3F;
      4'd1: dec7 = 7'h06;
      4'd2: dec7 = 7'h5B;
      4'd3: dec7 = 7'h4F;
      4'd4: dec7 = 7'h66;
      4'd5: dec7 = 7'h6D;
      4'd6: dec7 = 7'h7D;
      4'd7: dec7 = 7'h07;
      4'd8: dec7 = 7'h7F;
      4'd9: dec7 = 7'h6F;
      default: dec7 = 7'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frz_s1 <= 1'b0;
      frz_s2 <= 1'b0;
    end else begin
      frz_s1 <= freeze;
      frz_s2 <= frz_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_d    <= '0;
      lat_half <= 1'b0;
      lat_neg  <= 1'b0;
    end else if (load) begin
      lat_d    <= bcd_in[DW-1:0];
      lat_half <= half_in;
      lat_neg  <= neg_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp_cnt <= '0;
      bp     <= 1'b0;
    end else if (bp_cnt == CW'(BP_HALF - 1)) begin
      bp_cnt <= '0;
      bp     <= ~bp;
    end else begin
      bp_cnt <= bp_cnt + 1'b1;
    end
  end

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign pat[i] = dec7(lat_d[4*i +: 4]) ^ {7{bp}};
  end

  assign seg_units = pat[0];
  assign seg_tens  = pat[1];
  assign seg_hund  = pat[DIGITS-1];
  assign seg_half  = lat_half ^ bp;
  assign seg_minus = lat_neg ^ bp;

  // R2
  run_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_stb && !frz_s2) |=> (lat_d == $past(bcd_in[DW-1:0]) && lat_half == $past(half_in)
                             && lat_neg == $past(neg_in)));

  // R3
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_stb && frz_s2) |=> ($stable(lat_d) && $stable(lat_half) && $stable(lat_neg)));

  // R3
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_stb |=> ($stable(lat_d) && $stable(lat_half) && $stable(lat_neg)));

  // R4
  sync_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_s1 != frz_s2) |=> (frz_s2 == $past(frz_s1)));

  // R5
  bp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_cnt != '0) |-> $stable(bp));

endmodule

// File: tb/sim_lcd_hold_drv.sv
module sim_lcd_hold_drv;
  localparam int CONV = 400;
  localparam int HALF = CONV / 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eoc_stb = 1'b0, freeze = 1'b0, half_in = 1'b0, neg_in = 1'b0;
  logic [11:0] bcd_in = '0;
  logic [6:0] seg_units, seg_tens, seg_hund;
  logic seg_half, seg_minus, bp;

  int checks = 0, fails = 0;
  bit done = 0;

  lcd_hold_drv #(.CONV_CLKS(CONV)) u0 (
    .clk(clk), .rst_n(rst_n), .eoc_stb(eoc_stb), .freeze(freeze),
    .bcd_in(bcd_in), .half_in(half_in), .neg_in(neg_in),
    .seg_units(seg_units), .seg_tens(seg_tens), .seg_hund(seg_hund),
    .seg_half(seg_half), .seg_minus(seg_minus), .bp(bp));

  always #2 clk = ~clk;

  // {freeze, half, neg, hundreds, tens, units}
  localparam logic [14:0] VEC [10] = '{
    {1'b0, 1'b0, 1'b0, 4'd1, 4'd2, 4'd3},
    {1'b0, 1'b1, 1'b1, 4'd9, 4'd9, 4'd9},
    {1'b1, 1'b0, 1'b0, 4'd4, 4'd5, 4'd6},
    {1'b0, 1'b0, 1'b1, 4'd7, 4'd8, 4'd0},
    {1'b0, 1'b1, 1'b0, 4'd5, 4'd4, 4'd6},
    {1'b1, 1'b1, 1'b1, 4'd0, 4'd0, 4'd0},
    {1'b0, 1'b0, 1'b0, 4'd10, 4'd15, 4'd12},
    {1'b0, 1'b1, 1'b0, 4'd13, 4'd1, 4'd11},
    {1'b1, 1'b0, 1'b1, 4'd8, 4'd8, 4'd8},
    {1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0}
  };

  function automatic logic [6:0] ref7(input logic [3:0] v);
    case (v)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [22:0] act, input logic [22:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_disp(input string tag, input logic [11:0] d, input logic h, input logic n);
    logic [22:0] act, exp;
    act = {seg_minus, seg_half, seg_hund, seg_tens, seg_units} ^ {23{bp}};
    exp = {n, h, ref7(d[11:8]), ref7(d[7:4]), ref7(d[3:0])};
    chk(tag, act, exp);
  endtask

  task automatic strobe(input logic [11:0] d, input logic h, input logic n);
    bcd_in = d; half_in = h; neg_in = n; eoc_stb = 1'b1;
    @(negedge clk);
    eoc_stb = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] md;
    logic mh, mn;
    int toggles, gap;
    logic prev;
    repeat (3) @(negedge clk);
    // R1: reset contents and backplane
    chk("R1 reset bp", {22'd0, bp}, 23'd0);
    chk("R1 reset pattern", {seg_minus, seg_half, seg_hund, seg_tens, seg_units},
        {1'b0, 1'b0, 7'h3F, 7'h3F, 7'h3F});
    rst_n = 1'b1;
    @(negedge clk);
    chk_disp("R1 after release", 12'h000, 1'b0, 1'b0);

    // Vector walk: R2 R3 R7 R8 R9
    md = 12'h000; mh = 1'b0; mn = 1'b0;
    for (int i = 0; i < 10; i++) begin
      logic [14:0] v;
      v = VEC[i];
      if (v[14]) begin
        freeze = 1'b1;
        repeat (3) @(negedge clk);
      end
      strobe(v[11:0], v[13], v[12]);
      if (!v[14]) begin md = v[11:0]; mh = v[13]; mn = v[12]; end
      chk_disp(v[14] ? "R3 frozen vector" : "R2 R7 R8 R9 vector", md, mh, mn);
      if (v[14]) begin
        strobe(12'h321, 1'b1, 1'b1);
        chk_disp("R3 second frozen strobe", md, mh, mn);
        freeze = 1'b0;
        repeat (3) @(negedge clk);
        chk_disp("R3 still held after release", md, mh, mn);
      end
    end

    // R6: check both backplane phases with a lit and unlit segment
    strobe(12'h188, 1'b1, 1'b0);
    while (bp !== 1'b1) @(negedge clk);
    chk("R6 on seg antiphase bp=1", {22'd0, seg_half}, 23'd0);
    chk("R6 off seg inphase bp=1", {22'd0, seg_minus}, 23'd1);
    chk_disp("R6 pattern bp=1", 12'h188, 1'b1, 1'b0);
    while (bp !== 1'b0) @(negedge clk);
    chk("R6 on seg antiphase bp=0", {22'd0, seg_half}, 23'd1);
    chk_disp("R6 pattern bp=0", 12'h188, 1'b1, 1'b0);

    // R4: rise of freeze coincides with a strobe
    freeze = 1'b1;
    strobe(12'h111, 1'b0, 1'b0);
    chk_disp("R4 strobe at edge j loads", 12'h111, 1'b0, 1'b0);
    strobe(12'h222, 1'b0, 1'b1);
    chk_disp("R4 strobe at edge j+1 loads", 12'h222, 1'b0, 1'b1);
    strobe(12'h333, 1'b1, 1'b0);
    chk_disp("R4 strobe at edge j+2 blocked", 12'h222, 1'b0, 1'b1);
    // R4: fall of freeze coincides with a strobe
    freeze = 1'b0;
    strobe(12'h444, 1'b1, 1'b1);
    chk_disp("R4 release strobe j blocked", 12'h222, 1'b0, 1'b1);
    strobe(12'h555, 1'b1, 1'b1);
    chk_disp("R4 release strobe j+1 blocked", 12'h222, 1'b0, 1'b1);
    strobe(12'h666, 1'b1, 1'b1);
    chk_disp("R4 release strobe j+2 loads", 12'h666, 1'b1, 1'b1);

    // R5: half-period and toggles per conversion
    prev = bp;
    while (bp === prev) @(negedge clk);
    prev = bp; gap = 0;
    while (bp === prev) begin @(negedge clk); gap++; end
    chk("R5 half period", 23'(gap), 23'(HALF));
    toggles = 0; prev = bp;
    for (int c = 0; c < CONV; c++) begin
      @(negedge clk);
      if (bp !== prev) toggles++;
      prev = bp;
    end
    chk("R5 toggles per conversion", 23'(toggles), 23'd40);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule